// File: doc/BRIEF.md
# Two-Level Block Lookahead Adder

This block is a purely combinational unsigned adder. It takes two operands of `WIDTH` bits and a carry input, and returns a `WIDTH`-bit sum and a carry output. The operands are split into `WIDTH/GROUP` slices of `GROUP` bits each.

Each slice runs a small lookahead network. That network forms every carry inside the slice directly from the bit propagate and generate terms. It also hands up a slice-level propagate and a slice-level generate.

A second network of the same kind takes those slice-level signals and the external carry. From them it forms the carry that enters each slice and the final carry out. No carry ripples from one slice to the next. The default shape is 16 bits in slices of 4. The block is meant to sit between pipeline registers that the surrounding design provides.

Top module: `bcla_adder`

## Requirements
- R1: For every pair of operands and either carry input, `{carry_o, sum_o}` equals `op_a + op_b + carry_in` taken as a `WIDTH+1`-bit unsigned value.
- R2: For each bit, the propagate term is `a XOR b` and the generate term is `a AND b`. For each bit and each slice, propagate and generate are never both 1.
- R3: The propagate of a slice is the AND of its bit propagates. When a slice propagates, its carry out equals its carry in. For example, with `op_b = ~op_a` every sum bit is `~carry_in` and `carry_o` equals `carry_in`.
- R4: The carry that enters slice k (k ≥ 1) from the second-level network equals bit `k*GROUP` of `(op_a mod 2^(k*GROUP)) + (op_b mod 2^(k*GROUP)) + carry_in`. It also equals the carry out that slice k−1 forms internally.
- R5: `carry_o` is 1 exactly when `op_a + op_b + carry_in ≥ 2^WIDTH`. For example, all ones plus a carry in of 1 gives a sum of zero and `carry_o = 1`.
- R6: Zero operands with a zero carry input give a zero sum and `carry_o = 0`.
- R7: R1 holds for any `WIDTH` that is a multiple of `GROUP`. This includes the default 16/4 shape and a narrow 8/2 shape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | first addend |
| op_b | input | WIDTH | second addend |
| carry_in | input | 1 | carry into bit 0 |
| sum_o | output | WIDTH | sum bits |
| carry_o | output | 1 | carry out of the top bit |

## Verification
The in-line checks assume known 0/1 values on `op_a`, `op_b` and `carry_in`, and they skip evaluation while any of them is unknown. They also assume that the two lookahead levels see bit terms that come from real operand bits. Only then do propagate and generate exclude each other. The bench always drives fully known operands through the top-level ports and never forces internal signals. It sweeps every operand pair and carry value on an 8/2 instance, and runs corner patterns plus random vectors on the 16/4 instance.

// File: rtl/bcla_pkg.sv
`timescale 1ns/1ps
package bcla_pkg;
  localparam int unsigned DEF_WIDTH = 16;
  localparam int unsigned DEF_GROUP = 4;

  function automatic int unsigned slice_count(int unsigned w, int unsigned g);
    return w / g;
  endfunction
endpackage

// File: rtl/bcla_bitpg.sv
`timescale 1ns/1ps
module bcla_bitpg #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o,
  output logic [W-1:0] g_o
);
  always_comb begin
    p_o = a_i ^ b_i;
    g_o = a_i & b_i;
  end

  // R2: a bit can never both propagate and generate
  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      a_r2_bit_exclusive: assert ((p_o & g_o) == '0)
        else $error("bit propagate and generate overlap");
    end
  end
endmodule

// File: rtl/bcla_lookahead.sv
`timescale 1ns/1ps
module bcla_lookahead #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] g_i,
  input  logic         c_i,
  output logic [W-1:0] c_o,
  output logic         grp_p_o,
  output logic         grp_g_o,
  output logic         cout_o
);
  logic [W:0] carr;

  // Sum-of-products carry for every position, no rippling term
  always_comb begin
    logic term;
    logic acc;
    for (int i = 0; i <= W; i++) begin
      term = c_i;
      for (int k = 0; k < i; k++) term = term & p_i[k];
      acc = term;
      for (int j = 0; j < i; j++) begin
        term = g_i[j];
        for (int k = j + 1; k < i; k++) term = term & p_i[k];
        acc = acc | term;
      end
      carr[i] = acc;
    end
  end

  always_comb begin
    logic term;
    logic acc;
    acc = 1'b0;
    for (int j = 0; j < W; j++) begin
      term = g_i[j];
      for (int k = j + 1; k < W; k++) term = term & p_i[k];
      acc = acc | term;
    end
    grp_g_o = acc;
    grp_p_o = &p_i;
  end

  assign c_o    = carr[W-1:0];
  assign cout_o = carr[W];

  always_comb begin
    if (!$isunknown({p_i, g_i, c_i})) begin
      // R2: slice-level terms exclude each other
      a_r2_group_exclusive: assert (!(grp_p_o && grp_g_o))
        else $error("group propagate and generate both set");
      // R3: a propagating slice passes its carry through
      a_r3_prop_passes: assert (!grp_p_o || (cout_o == c_i))
        else $error("propagating group altered carry");
      // R3: a generating slice always emits a carry
      a_r3_gen_emits: assert (!grp_g_o || cout_o)
        else $error("generating group lost carry");
    end
  end
endmodule

// File: rtl/bcla_adder.sv
`timescale 1ns/1ps
module bcla_adder
  import bcla_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned GROUP = DEF_GROUP
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  localparam int unsigned NGRP = slice_count(WIDTH, GROUP);

  logic [WIDTH-1:0] bit_p, bit_g, bit_c;
  logic [NGRP-1:0]  grp_p, grp_g, grp_cin, grp_cout;
  logic             top_p, top_g;

  bcla_bitpg #(.W(WIDTH)) u_pg (
    .a_i(op_a), .b_i(op_b), .p_o(bit_p), .g_o(bit_g)
  );

  for (genvar k = 0; k < NGRP; k++) begin : g_slice
    bcla_lookahead #(.W(GROUP)) u_slice (
      .p_i    (bit_p[k*GROUP +: GROUP]),
      .g_i    (bit_g[k*GROUP +: GROUP]),
      .c_i    (grp_cin[k]),
      .c_o    (bit_c[k*GROUP +: GROUP]),
      .grp_p_o(grp_p[k]),
      .grp_g_o(grp_g[k]),
      .cout_o (grp_cout[k])
    );
  end

  bcla_lookahead #(.W(NGRP)) u_second (
    .p_i    (grp_p),
    .g_i    (grp_g),
    .c_i    (carry_in),
    .c_o    (grp_cin),
    .grp_p_o(top_p),
    .grp_g_o(top_g),
    .cout_o (carry_o)
  );

  assign sum_o = bit_p ^ bit_c;

  always_comb begin
    logic [WIDTH:0] ref_sum;
    ref_sum = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    if (!$isunknown({op_a, op_b, carry_in})) begin
      a_r1_sum_matches: assert ({carry_o, sum_o} == ref_sum)
        else $error("sum mismatch");
      a_r5_top_gen_carries: assert (!top_g || carry_o)
        else $error("top generate without carry out");
      a_r5_top_prop_passes: assert (!top_p || (carry_o == carry_in))
        else $error("top propagate altered carry");
      // R4: second-level carry into slice k+1 agrees with slice k's own carry out
      for (int k = 0; k < NGRP - 1; k++) begin
        a_r4_level_agree: assert (grp_cout[k] == grp_cin[k+1])
          else $error("level carries disagree at slice %0d", k);
      end
      a_r4_last_slice: assert (grp_cout[NGRP-1] == carry_o)
        else $error("last slice carry disagrees with carry out");
    end
  end
endmodule

// File: tb/bcla_adder_tb.sv
`timescale 1ns/1ps
module bcla_adder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [15:0] a16, b16, s16;
  logic        c16, co16;
  logic [7:0]  a8, b8, s8;
  logic        c8, co8;

  bcla_adder #(.WIDTH(16), .GROUP(4)) u_dut (
    .op_a(a16), .op_b(b16), .carry_in(c16), .sum_o(s16), .carry_o(co16)
  );
  bcla_adder #(.WIDTH(8), .GROUP(2)) u_dut_small (
    .op_a(a8), .op_b(b8), .carry_in(c8), .sum_o(s8), .carry_o(co8)
  );

  task automatic chk16(input logic [15:0] a, input logic [15:0] b,
                       input logic c, input string req);
    logic [16:0] exp;
    a16 = a; b16 = b; c16 = c;
    #1;
    exp = {1'b0, a} + {1'b0, b} + {16'd0, c};
    n_tests++;
    if ({co16, s16} !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%0d got=%h exp=%h", req, a, b, c, {co16, s16}, exp);
    end
    // R4: carry into each slice, recovered from the sum bit at the slice boundary
    for (int k = 1; k < 4; k++) begin
      logic [16:0] mask, lo;
      logic got_c;
      mask  = (17'd1 << (4 * k)) - 17'd1;
      lo    = ({1'b0, a} & mask) + ({1'b0, b} & mask) + {16'd0, c};
      got_c = s16[4*k] ^ a[4*k] ^ b[4*k];
      n_tests++;
      if (got_c !== lo[4*k]) begin
        n_fail++;
        $display("FAIL R4 slice %0d a=%h b=%h cin=%0d got=%0d exp=%0d",
                 k, a, b, c, got_c, lo[4*k]);
      end
    end
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    a16 = '0; b16 = '0; c16 = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R6: zero in, zero out
    n_tests++;
    if ({co16, s16} !== 17'd0) begin
      n_fail++;
      $display("FAIL R6 got=%h exp=0", {co16, s16});
    end
    chk16(16'h0000, 16'h0000, 1'b0, "R6");
    chk16(16'h0000, 16'h0000, 1'b1, "R1");

    // R5: overflow boundaries
    chk16(16'hFFFF, 16'h0000, 1'b1, "R5");
    chk16(16'hFFFF, 16'hFFFF, 1'b1, "R5");
    chk16(16'hFFFF, 16'hFFFF, 1'b0, "R5");
    chk16(16'h8000, 16'h8000, 1'b0, "R5");
    chk16(16'hFFFE, 16'h0001, 1'b0, "R5");
    n_tests++;
    a16 = 16'hFFFF; b16 = 16'h0000; c16 = 1'b1; #1;
    if (co16 !== 1'b1 || s16 !== 16'h0000) begin
      n_fail++;
      $display("FAIL R5 got=%h exp=10000", {co16, s16});
    end
    #1;

    // R3: full propagate, b = ~a
    for (int i = 0; i < 8; i++) begin
      logic [15:0] pat;
      pat = (i == 0) ? 16'hAAAA : (i == 1) ? 16'h5555 : (i == 2) ? 16'hF0F0 :
            (i == 3) ? 16'h0F0F : 16'(32'h1234 * (i + 1));
      for (int c = 0; c < 2; c++) begin
        a16 = pat; b16 = ~pat; c16 = c[0]; #1;
        n_tests++;
        if (s16 !== {16{~c[0]}} || co16 !== c[0]) begin
          n_fail++;
          $display("FAIL R3 a=%h cin=%0d got=%h exp=%h", pat, c, {co16, s16},
                   {c[0], {16{~c[0]}}});
        end
        #1;
      end
    end

    // R1: alternating and single-bit patterns
    chk16(16'hAAAA, 16'hAAAA, 1'b0, "R1");
    chk16(16'h5555, 16'h5555, 1'b1, "R1");
    chk16(16'hAAAA, 16'h5555, 1'b1, "R1");
    chk16(16'h000F, 16'h0001, 1'b0, "R1");
    chk16(16'h00FF, 16'h0001, 1'b0, "R1");
    chk16(16'h0FFF, 16'h0000, 1'b1, "R1");
    for (int i = 0; i < 16; i++) chk16(16'(1 << i), 16'(1 << i), 1'b0, "R1");

    // R1/R2: random vectors
    for (int i = 0; i < 3000; i++)
      chk16(16'($urandom), 16'($urandom), 1'($urandom), "R1");

    // R7: exhaustive sweep of the 8/2 shape
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        for (int c = 0; c < 2; c++) begin
          logic [8:0] exp;
          a8 = 8'(x); b8 = 8'(y); c8 = c[0];
          #1;
          exp = 9'(x + y + c);
          n_tests++;
          if ({co8, s8} !== exp) begin
            n_fail++;
            $display("FAIL R7 a=%h b=%h cin=%0d got=%h exp=%h", a8, b8, c, {co8, s8}, exp);
          end
        end
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule